// File: doc/BRIEF.md
# Set-Associative Tag and Payload Store

This block holds tagged payloads in an N-way set-associative arrangement, sized for a small cache or a translation buffer. Every request carries a set index, a tag and, for writes, a payload. The set index addresses all way arrays at once. A read compares the tag against every way of that set in parallel. The registered response one cycle later reports a hit, the way that matched and the stored payload.

A write first looks for the tag in the indexed set. If the tag is present, that way's payload is updated in place. Otherwise a replacement unit names a victim way. The tag and payload are written there and the entry's valid flag is set. The flag is the least significant bit of the stored word.

An elaboration parameter picks the victim picker. One choice is a tree pseudo-LRU with its own state for every set. The other is one shared linear-feedback shift register that picks a way at random, without looking for empty ways. Only the selected picker is built. Two saturating counters tally read hits and read misses, so the two policies can be compared on the same access trace.

Top module: `setassoc_store`

## Requirements
- R1: The response outputs register the result of a read one cycle after the request. `rsp_valid_o` is high in exactly the cycle after a read request and low after a write or an idle cycle.
- R2: A read hits only when some way of the indexed set has its valid flag set and a stored tag equal to the request tag. A hit returns that way's index and payload. On a miss, way and payload read as zero. Reset clears every valid flag, so a tag of zero misses after reset.
- R3: A write whose tag is already valid in the indexed set overwrites that way's payload. It makes no new victim choice and does not step the random generator.
- R4: A write whose tag is absent stores the tag and payload in the victim way with the valid flag (bit 0 of the entry) set. A later read of that set and tag hits with that payload.
- R5: Pseudo-LRU mode keeps WAYS-1 tree bits per set in heap order: node 0 is the root and node i has children 2i+1 (lower ways) and 2i+2 (upper ways). A bit of 0 points to the lower half. The victim is found by following the bits from the root. A read hit or any write sets each node on the accessed way's path to point away from it. With 4 ways, an untouched set fills ways 0, 2, 1, 3 in that order.
- R6: Each set has its own replacement state. Accesses to one set do not change the victim chosen in another set.
- R7: Random mode uses an 8-bit shift register seeded to 0x01. Its taps are exponents {8,6,5,4}, with exponent 0 implied. Each step shifts left and loads bit 0 with the XOR of bits 7, 5, 4 and 3. The victim is the low log2(WAYS) bits of the state before the step. The register steps only on writes that miss, and may overwrite a valid way while another way of the set is empty.
- R8: The hit and miss counters count read hits and read misses. Each updates in the same cycle as the response and holds at 2^CNT_W-1. Both are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present this cycle |
| req_write_i | input | 1 | 1 = write/fill, 0 = read |
| req_set_i | input | SET_W | Set index |
| req_tag_i | input | TAG_W | Tag to match or store |
| req_data_i | input | DATA_W | Payload for writes |
| rsp_valid_o | output | 1 | Read response valid |
| rsp_hit_o | output | 1 | Read found a valid matching tag |
| rsp_way_o | output | WAY_W | Way that matched |
| rsp_data_o | output | DATA_W | Payload of the matching way |
| hit_cnt_o | output | CNT_W | Saturating read-hit count |
| miss_cnt_o | output | CNT_W | Saturating read-miss count |

## Verification
Filling an empty set and then reading every tag back exposes the tree's victim order. Reusing one way then steers the next fill to a predicted way, which tells a true tree from round-robin or lowest-empty selection. In random mode, four fills of one set are checked against a model of the shift register. The model predicts an overwrite while a way is still empty, which tells a free-running random pick from one that prefers empty ways. Rewriting a stored tag, looking up a zero tag in reset entries and reading one tag in two sets separate in-place update, valid gating and per-set state. A run of misses drives the narrow counter into saturation.

// File: rtl/setassoc_pkg.sv
package setassoc_pkg;
  typedef enum logic {
    REPL_PLRU = 1'b0,
    REPL_LFSR = 1'b1
  } repl_e;
endpackage

// File: rtl/setassoc_way.sv
module setassoc_way #(
  parameter int SETS  = 16,
  parameter int ENT_W = 8,
  localparam int SET_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SET_W-1:0] set_i,
  input  logic [ENT_W-1:0] wdata_i,
  output logic [ENT_W-1:0] rdata_o
);
  logic [ENT_W-1:0] mem_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) mem_q[s] <= '0;
    end else if (we_i) begin
      mem_q[set_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[set_i];
endmodule

// File: rtl/setassoc_plru.sv
module setassoc_plru #(
  parameter int SETS = 16,
  parameter int WAYS = 4,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS),
  localparam int NODES = WAYS - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_i,
  input  logic             upd_i,
  input  logic [WAY_W-1:0] upd_way_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] cur, nxt;

  assign cur = tree_q[set_i];

  // walk from root following pointer bits
  always_comb begin
    logic [WAY_W-1:0] idx;
    idx      = '0;
    victim_o = '0;
    for (int l = 0; l < WAY_W; l++) begin
      victim_o[WAY_W-1-l] = cur[idx];
      idx = (idx << 1) + WAY_W'(1) + WAY_W'(cur[idx]);
    end
  end

  // point every node on the accessed path away from it
  always_comb begin
    logic [WAY_W-1:0] idx;
    logic             b;
    idx = '0;
    nxt = cur;
    for (int l = 0; l < WAY_W; l++) begin
      b        = upd_way_i[WAY_W-1-l];
      nxt[idx] = ~b;
      idx      = (idx << 1) + WAY_W'(1) + WAY_W'(b);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else if (upd_i) begin
      tree_q[set_i] <= nxt;
    end
  end
endmodule

// File: rtl/setassoc_lfsr.sv
module setassoc_lfsr #(
  parameter int                WAYS   = 4,
  parameter int                LFSR_W = 8,
  // bit k set = exponent k present; exponent 0 is implicit
  parameter logic [LFSR_W:0]   TAPS   = 9'b1_0111_0001,
  parameter logic [LFSR_W-1:0] SEED   = 8'h01,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [WAY_W-1:0] victim_o
);
  logic [LFSR_W-1:0] state_q;
  logic              fb;

  assign fb       = ^(state_q & TAPS[LFSR_W:1]);
  assign victim_o = state_q[WAY_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= {state_q[LFSR_W-2:0], fb};
  end
endmodule

// File: rtl/setassoc_satcnt.sv
module setassoc_satcnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   count_o <= '0;
    else if (inc_i && !(&count_o)) count_o <= count_o + W'(1);
  end
endmodule

// File: rtl/setassoc_store.sv
module setassoc_store #(
  parameter int                  WAYS   = 4,
  parameter int                  SETS   = 16,
  parameter int                  TAG_W  = 8,
  parameter int                  DATA_W = 16,
  parameter int                  CNT_W  = 16,
  parameter setassoc_pkg::repl_e POLICY = setassoc_pkg::REPL_PLRU,
  parameter int                  LFSR_W = 8,
  parameter logic [LFSR_W:0]     TAPS   = 9'b1_0111_0001,
  parameter logic [LFSR_W-1:0]   SEED   = 8'h01,
  localparam int SET_W = $clog2(SETS),
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [SET_W-1:0]  req_set_i,
  input  logic [TAG_W-1:0]  req_tag_i,
  input  logic [DATA_W-1:0] req_data_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic [WAY_W-1:0]  rsp_way_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  localparam int ENT_W = TAG_W + DATA_W + 1;

  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [DATA_W-1:0] data;
    logic              valid;  // bit 0
  } entry_t;

  logic             rd_req, wr_en, hit_any;
  logic [WAYS-1:0]  hit_vec, we_vec;
  logic [WAY_W-1:0] hit_way, victim, acc_way;
  logic [DATA_W-1:0] hit_data;
  logic [ENT_W-1:0] rd_raw [WAYS];
  entry_t           rd_entry [WAYS];
  entry_t           wr_entry;

  assign rd_req   = req_valid_i && !req_write_i;
  assign wr_en    = req_valid_i && req_write_i;
  assign wr_entry = '{tag: req_tag_i, data: req_data_i, valid: 1'b1};
  assign acc_way  = hit_any ? hit_way : victim;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    setassoc_way #(.SETS(SETS), .ENT_W(ENT_W)) u_way (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (we_vec[w]),
      .set_i   (req_set_i),
      .wdata_i (wr_entry),
      .rdata_o (rd_raw[w])
    );
    assign rd_entry[w] = entry_t'(rd_raw[w]);
    assign hit_vec[w]  = rd_entry[w].valid && (rd_entry[w].tag == req_tag_i);
    assign we_vec[w]   = wr_en && (acc_way == WAY_W'(w));
  end

  assign hit_any = |hit_vec;

  // lowest matching way wins (duplicates cannot be created)
  always_comb begin
    hit_way  = '0;
    hit_data = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        hit_way  = WAY_W'(w);
        hit_data = rd_entry[w].data;
      end
    end
  end

  if (POLICY == setassoc_pkg::REPL_PLRU) begin : g_plru
    logic touch;
    assign touch = req_valid_i && (req_write_i || hit_any);
    setassoc_plru #(.SETS(SETS), .WAYS(WAYS)) u_repl (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_i     (req_set_i),
      .upd_i     (touch),
      .upd_way_i (acc_way),
      .victim_o  (victim)
    );
  end else begin : g_lfsr
    logic fill;
    assign fill = wr_en && !hit_any;
    setassoc_lfsr #(.WAYS(WAYS), .LFSR_W(LFSR_W), .TAPS(TAPS), .SEED(SEED)) u_repl (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .step_i   (fill),
      .victim_o (victim)
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_way_o   <= '0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= rd_req;
      rsp_hit_o   <= rd_req && hit_any;
      rsp_way_o   <= (rd_req && hit_any) ? hit_way : '0;
      rsp_data_o  <= (rd_req && hit_any) ? hit_data : '0;
    end
  end

  setassoc_satcnt #(.W(CNT_W)) u_hit_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (rd_req && hit_any),
    .count_o (hit_cnt_o)
  );

  setassoc_satcnt #(.W(CNT_W)) u_miss_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .inc_i   (rd_req && !hit_any),
    .count_o (miss_cnt_o)
  );
endmodule

// File: rtl/setassoc_store_chk.sv
module setassoc_store_chk #(
  parameter int SET_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 16,
  parameter int WAY_W  = 2,
  parameter int CNT_W  = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_write_i,
  input logic [SET_W-1:0]  req_set_i,
  input logic [TAG_W-1:0]  req_tag_i,
  input logic [DATA_W-1:0] req_data_i,
  input logic              rsp_valid_o,
  input logic              rsp_hit_o,
  input logic [WAY_W-1:0]  rsp_way_o,
  input logic [DATA_W-1:0] rsp_data_o,
  input logic [CNT_W-1:0]  hit_cnt_o,
  input logic [CNT_W-1:0]  miss_cnt_o
);
  assert_rsp_after_read_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);

  assert_no_rsp_otherwise_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && !req_write_i) |=> !rsp_valid_o);

  assert_hit_needs_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_hit_o |-> rsp_valid_o);

  assert_miss_zeroed_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_hit_o |-> (rsp_way_o == '0 && rsp_data_o == '0));

  assert_fill_then_hit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_write_i && $past(rst_ni) && $past(req_valid_i && req_write_i)
     && req_set_i == $past(req_set_i) && req_tag_i == $past(req_tag_i))
    |=> (rsp_hit_o && rsp_data_o == $past(req_data_i, 2)));

  assert_hit_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && rsp_hit_o) |-> $stable(hit_cnt_o));

  assert_hit_cnt_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_hit_o && !(&$past(hit_cnt_o)))
    |-> hit_cnt_o == $past(hit_cnt_o) + CNT_W'(1));

  assert_miss_cnt_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_valid_o && !rsp_hit_o) |-> $stable(miss_cnt_o));

  assert_miss_cnt_sat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&$past(miss_cnt_o)) |-> (&miss_cnt_o));
endmodule

bind setassoc_store setassoc_store_chk #(
  .SET_W(SET_W), .TAG_W(TAG_W), .DATA_W(DATA_W), .WAY_W(WAY_W), .CNT_W(CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_write_i (req_write_i),
  .req_set_i   (req_set_i),
  .req_tag_i   (req_tag_i),
  .req_data_i  (req_data_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_hit_o   (rsp_hit_o),
  .rsp_way_o   (rsp_way_o),
  .rsp_data_o  (rsp_data_o),
  .hit_cnt_o   (hit_cnt_o),
  .miss_cnt_o  (miss_cnt_o)
);

// File: tb/tb_setassoc_store.sv
`timescale 1ns/1ps
module tb_setassoc_store;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic        rv [2];
  logic        rw [2];
  logic [3:0]  rs [2];
  logic [7:0]  rt [2];
  logic [15:0] rdat [2];
  logic        ov [2];
  logic        oh [2];
  logic [1:0]  ow [2];
  logic [15:0] od [2];
  logic [15:0] hc0, mc0;
  logic [2:0]  hc1, mc1;

  int n_chk = 0, n_fail = 0;
  int exp_hits [2];
  int exp_miss [2];
  bit done = 0;

  setassoc_store #(.CNT_W(16), .POLICY(setassoc_pkg::REPL_PLRU)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv[0]), .req_write_i(rw[0]),
    .req_set_i(rs[0]), .req_tag_i(rt[0]), .req_data_i(rdat[0]),
    .rsp_valid_o(ov[0]), .rsp_hit_o(oh[0]), .rsp_way_o(ow[0]), .rsp_data_o(od[0]),
    .hit_cnt_o(hc0), .miss_cnt_o(mc0));

  setassoc_store #(.CNT_W(3), .POLICY(setassoc_pkg::REPL_LFSR)) dut_lfsr (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(rv[1]), .req_write_i(rw[1]),
    .req_set_i(rs[1]), .req_tag_i(rt[1]), .req_data_i(rdat[1]),
    .rsp_valid_o(ov[1]), .rsp_hit_o(oh[1]), .rsp_way_o(ow[1]), .rsp_data_o(od[1]),
    .hit_cnt_o(hc1), .miss_cnt_o(mc1));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle(int sel);
    rv[sel] = 1'b0; rw[sel] = 1'b0;
  endtask

  task automatic check_counts(int sel);
    int mx = sel ? 7 : 65535;
    int eh = exp_hits[sel] > mx ? mx : exp_hits[sel];
    int em = exp_miss[sel] > mx ? mx : exp_miss[sel];
    int ah = sel ? int'(hc1) : int'(hc0);
    int am = sel ? int'(mc1) : int'(mc0);
    chk(ah == eh, "R8", "hit count", ah, eh);
    chk(am == em, "R8", "miss count", am, em);
  endtask

  task automatic wr(int sel, int set, int tag, int data);
    @(negedge clk);
    rv[sel] = 1'b1; rw[sel] = 1'b1;
    rs[sel] = 4'(set); rt[sel] = 8'(tag); rdat[sel] = 16'(data);
    @(negedge clk);
    idle(sel);
    chk(ov[sel] == 1'b0, "R1", "rsp_valid after write", int'(ov[sel]), 0);
  endtask

  task automatic rd(int sel, int set, int tag, bit eh, int ew, int ed, string req);
    @(negedge clk);
    rv[sel] = 1'b1; rw[sel] = 1'b0;
    rs[sel] = 4'(set); rt[sel] = 8'(tag);
    @(negedge clk);
    idle(sel);
    if (eh) exp_hits[sel]++; else exp_miss[sel]++;
    chk(ov[sel] == 1'b1, "R1", "rsp_valid after read", int'(ov[sel]), 1);
    chk(oh[sel] == eh, req, $sformatf("hit set %0d tag %0h", set, tag), int'(oh[sel]), int'(eh));
    chk(ow[sel] == 2'(eh ? ew : 0), req, "way", int'(ow[sel]), eh ? ew : 0);
    chk(od[sel] == 16'(eh ? ed : 0), req, "data", int'(od[sel]), eh ? ed : 0);
    check_counts(sel);
  endtask

  function automatic logic [7:0] lfsr_next(logic [7:0] s);
    return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
  endfunction

  task automatic t_reset();
    for (int s = 0; s < 2; s++) begin
      chk(ov[s] == 1'b0, "R1", "rsp_valid at reset", int'(ov[s]), 0);
      check_counts(s);
    end
    // zero tag matches cleared entries but valid is 0
    rd(0, 0, 8'h00, 0, 0, 0, "R2");
    rd(1, 0, 8'h00, 0, 0, 0, "R2");
  endtask

  task automatic t_plru_order();
    for (int i = 0; i < 4; i++) wr(0, 3, 8'h10 + i, 16'h1000 + i);
    rd(0, 3, 8'h10, 1, 0, 16'h1000, "R5");
    rd(0, 3, 8'h11, 1, 2, 16'h1001, "R5");
    rd(0, 3, 8'h12, 1, 1, 16'h1002, "R5");
    rd(0, 3, 8'h13, 1, 3, 16'h1003, "R4");
    rd(0, 3, 8'h10, 1, 0, 16'h1000, "R5");  // tree now points at way 2
    wr(0, 3, 8'h20, 16'h2000);
    rd(0, 3, 8'h20, 1, 2, 16'h2000, "R5");
    rd(0, 3, 8'h11, 0, 0, 0, "R2");
  endtask

  task automatic t_write_hit();
    wr(0, 3, 8'h10, 16'hBEEF);
    rd(0, 3, 8'h10, 1, 0, 16'hBEEF, "R3");
    rd(0, 3, 8'h13, 1, 3, 16'h1003, "R3");
  endtask

  task automatic t_set_isolation();
    rd(0, 4, 8'h10, 0, 0, 0, "R6");
    wr(0, 4, 8'h10, 16'h4444);
    rd(0, 4, 8'h10, 1, 0, 16'h4444, "R6");
    wr(0, 4, 8'h55, 16'h5555);
    rd(0, 4, 8'h55, 1, 2, 16'h5555, "R6");
  endtask

  task automatic t_lfsr();
    logic [7:0] ls = 8'h01;
    int vic [4];
    for (int i = 0; i < 4; i++) begin
      vic[i] = int'(ls[1:0]);
      ls = lfsr_next(ls);
      wr(1, 2, 8'h30 + i, 16'h3000 + i);
    end
    for (int i = 0; i < 4; i++) begin
      bit live = 1;
      for (int j = i + 1; j < 4; j++) if (vic[j] == vic[i]) live = 0;
      rd(1, 2, 8'h30 + i, live, vic[i], 16'h3000 + i, "R7");
    end
    // hit write must not step the generator
    wr(1, 2, 8'h31, 16'h3131);
    rd(1, 2, 8'h31, 1, vic[1], 16'h3131, "R3");
    wr(1, 2, 8'h34, 16'h3434);
    rd(1, 2, 8'h34, 1, int'(ls[1:0]), 16'h3434, "R7");
  endtask

  task automatic t_saturate();
    for (int i = 0; i < 10; i++) rd(1, 9, 8'hA0 + i, 0, 0, 0, "R8");
    chk(mc1 == 3'd7, "R8", "miss count saturated", int'(mc1), 7);
  endtask

  initial begin
    for (int s = 0; s < 2; s++) begin
      rv[s] = 0; rw[s] = 0; rs[s] = 0; rt[s] = 0; rdat[s] = 0;
      exp_hits[s] = 0; exp_miss[s] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_plru_order();
    t_write_hit();
    t_set_isolation();
    t_lfsr();
    t_saturate();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule